// File: doc/BRIEF.md
# Oscillator Stabilization Wait Gate

This block sits beside an on-chip oscillator and decides when that oscillator's clock may be handed to the rest of the chip. It drives the oscillator's run request from a software enable bit and a sleep request. Each time the oscillator starts again, it counts a settling interval in cycles of the oscillator's own clock. Until the interval is over, the system clock enable stays low.

The oscillator starts again at reset release, on leaving sleep, and when software turns the enable bit back on. The interval is picked by a two-bit code in which a larger code means a shorter wait. The code is captured when the count begins, so changing it during a wait has no effect on that wait. The gated enable that goes to the system clock tree is retimed on the falling edge of the oscillator clock, so it never cuts a high phase short. The register port, the counter and the sleep request all belong to the oscillator clock domain.

Top module: `osc_wait_gate`

## Requirements
- R1: While reset is held and right after it, the control register reads 0x04 (oscillator enabled, wait code 0), `osc_run` is 1 when `sleep_req` is low, and both `clk_ready` and `sys_clk_en` are 0.
- R2: `osc_run` equals the enable bit (register bit 2) ANDed with the inverse of `sleep_req`, so sleep stops the oscillator whatever the enable bit holds.
- R3: After a start, `clk_ready` becomes 1 following exactly N rising edges of `osc_clk` at which `osc_run` is high, with the first such edge counted as one. N is 64 for wait code 0, 32 for code 1, 16 for code 2 and 8 for code 3. The wait code is register bits 7:6. After reset, the reset-release edge is the first counted edge.
- R4: A low-to-high change of `osc_run` caused by `sleep_req` falling starts a complete new wait.
- R5: A register write that sets bit 2 from 0 to 1 starts a complete new wait on the next edge.
- R6: `clk_ready` falls in the same cycle that `osc_run` falls. A later restart always runs the full selected wait.
- R7: The wait code is sampled on the first edge of a wait. Rewriting bits 7:6 during the count does not change that wait.
- R8: `sys_clk_en` changes only on falling edges of `osc_clk`, and at each falling edge it takes the value `clk_ready` has at that moment.
- R9: The read value has the wait code in bits 7:6, `clk_ready` in bit 3 and the enable in bit 2. Bits 5:4 and 1:0 read 0. Writes to bits 5:3 and 1:0 are ignored.
- R10: Once `clk_ready` is 1, it stays 1 for as long as `osc_run` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Free-running clock from the oscillator model |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| sleep_req | input | 1 | Sleep request, forces the oscillator off |
| rd_data | output | 8 | Register read value |
| osc_run | output | 1 | Run request to the analog oscillator |
| clk_ready | output | 1 | Stabilization wait complete |
| sys_clk_en | output | 1 | Glitch-free enable for the system clock |

## Verification
The hardest case to reach is a rewrite of the wait code in the middle of a count. The write has to land after the wait has started and before it ends, and only the length of the wait shows whether the old code was kept. The bench stops and restarts the oscillator with one code, lets a few edges go by, writes the longest code, and then counts edges until ready against the short expected length. Random runs add sleep pulses and writes that land at arbitrary points of a wait. Every cycle is compared with a bench model.

// File: rtl/osc_wait_pkg.sv
// Shared constants and helpers for the oscillator wait gate.
// Assumes an 8-bit control register with fixed field positions.
package osc_wait_pkg;
    localparam int EN_BIT  = 2;
    localparam int RDY_BIT = 3;
    localparam int SEL_LSB = 6;
    localparam int SEL_W   = 2;

    // Wait length for a select code: a larger code gives a shorter wait.
    function automatic int unsigned wait_cycles(input logic [SEL_W-1:0] sel,
                                                input int unsigned base);
        return base << (2'd3 - sel);
    endfunction
endpackage

// File: rtl/osc_ctrl_reg.sv
// Control register holding the oscillator enable and the wait-select code.
// Assumes writes are synchronous to osc_clk. Bits outside the mask stay 0.
module osc_ctrl_reg
    import osc_wait_pkg::*;
#(
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic             osc_en,
    output logic [SEL_W-1:0] wait_sel,
    output logic [REG_W-1:0] stored
);
    localparam logic [REG_W-1:0] WR_MASK = REG_W'((1 << EN_BIT) | (3 << SEL_LSB));
    localparam logic [REG_W-1:0] RST_VAL = REG_W'(1 << EN_BIT);

    logic [REG_W-1:0] ctrl_q;

    // Register update: only the masked fields take write data.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= RST_VAL;
        else if (wr_en)
            ctrl_q <= (ctrl_q & ~WR_MASK) | (wr_data & WR_MASK);
    end

    assign osc_en   = ctrl_q[EN_BIT];
    assign wait_sel = ctrl_q[SEL_LSB +: SEL_W];
    assign stored   = ctrl_q & WR_MASK;
endmodule

// File: rtl/osc_stab_counter.sv
// Counts oscillator edges after every start and raises ready after the
// selected count. The select code is latched on the first edge of a wait.
// Assumes osc_run is synchronous to clk.
module osc_stab_counter
    import osc_wait_pkg::*;
#(
    parameter int unsigned BASE_WAIT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             osc_run,
    input  logic [SEL_W-1:0] wait_sel,
    output logic             ready
);
    localparam int unsigned MAX_WAIT = BASE_WAIT * 8;
    localparam int          CNT_W    = $clog2(MAX_WAIT + 1);

    logic             run_q;
    logic             ready_q;
    logic             start;
    logic [CNT_W-1:0] cnt_q, lim_q, cnt_nxt, lim_use;

    // Next-count decode: a start loads count 1 and a freshly sampled limit.
    always_comb begin
        start   = osc_run & ~run_q;
        lim_use = start ? CNT_W'(wait_cycles(wait_sel, BASE_WAIT)) : lim_q;
        cnt_nxt = start ? CNT_W'(1) : cnt_q + 1'b1;
    end

    // Counter and ready state: cleared while stopped, held once done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= 1'b0;
            cnt_q   <= '0;
            lim_q   <= CNT_W'(MAX_WAIT);
            ready_q <= 1'b0;
        end else begin
            run_q <= osc_run;
            if (!osc_run) begin
                cnt_q   <= '0;
                ready_q <= 1'b0;
            end else if (start || !ready_q) begin
                cnt_q   <= cnt_nxt;
                lim_q   <= lim_use;
                ready_q <= (cnt_nxt == lim_use);
            end
        end
    end

    assign ready = ready_q;
endmodule

// File: rtl/osc_clk_gate.sv
// Retimes the ready flag on the falling clock edge so the system clock
// enable never truncates a high phase. Assumes an AND-style clock gate downstream.
module osc_clk_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic ready_in,
    output logic gate_en
);
    // Falling-edge capture of the ready flag.
    always_ff @(negedge clk) begin
        if (!rst_n)
            gate_en <= 1'b0;
        else
            gate_en <= ready_in;
    end
endmodule

// File: rtl/osc_wait_gate.sv
// Top level: oscillator run control, stabilization counter and clock gate.
// Assumes sleep_req and register accesses are synchronous to osc_clk.
module osc_wait_gate
    import osc_wait_pkg::*;
#(
    parameter int unsigned BASE_WAIT = 8,
    parameter int          REG_W     = 8
) (
    input  logic             osc_clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             sleep_req,
    output logic [REG_W-1:0] rd_data,
    output logic             osc_run,
    output logic             clk_ready,
    output logic             sys_clk_en
);
    logic             osc_en;
    logic [SEL_W-1:0] wait_sel;
    logic [REG_W-1:0] stored;
    logic             rdy_q;

    osc_ctrl_reg #(.REG_W(REG_W)) u_reg (
        .clk      (osc_clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .osc_en   (osc_en),
        .wait_sel (wait_sel),
        .stored   (stored)
    );

    osc_stab_counter #(.BASE_WAIT(BASE_WAIT)) u_cnt (
        .clk      (osc_clk),
        .rst_n    (rst_n),
        .osc_run  (osc_run),
        .wait_sel (wait_sel),
        .ready    (rdy_q)
    );

    osc_clk_gate u_gate (
        .clk      (osc_clk),
        .rst_n    (rst_n),
        .ready_in (clk_ready),
        .gate_en  (sys_clk_en)
    );

    // Run request, ready qualification and read mux.
    always_comb begin
        osc_run   = osc_en & ~sleep_req;
        clk_ready = rdy_q & osc_run;
        rd_data   = stored | (REG_W'(clk_ready) << RDY_BIT);
    end
endmodule

// File: rtl/osc_wait_gate_chk.sv
// Property checker for osc_wait_gate, attached by bind.
module osc_wait_gate_chk #(
    parameter int unsigned BASE_WAIT = 8
) (
    input logic       osc_clk,
    input logic       rst_n,
    input logic       sleep_req,
    input logic [7:0] rd_data,
    input logic       osc_run,
    input logic       clk_ready,
    input logic       sys_clk_en
);
    logic [7:0] run_cnt;

    // Consecutive edges with the oscillator running (saturating).
    always_ff @(posedge osc_clk) begin
        if (!rst_n)
            run_cnt <= '0;
        else if (!osc_run)
            run_cnt <= '0;
        else if (run_cnt != 8'hFF)
            run_cnt <= run_cnt + 8'd1;
    end

    p_sleep_stops_r2: assert property (@(posedge osc_clk) disable iff (!rst_n)
        sleep_req |-> !osc_run);

    p_ready_needs_run_r6: assert property (@(posedge osc_clk) disable iff (!rst_n)
        clk_ready |-> osc_run);

    p_restart_not_ready_r4: assert property (@(posedge osc_clk) disable iff (!rst_n)
        $rose(osc_run) |-> !clk_ready);

    p_min_wait_r3: assert property (@(posedge osc_clk) disable iff (!rst_n)
        clk_ready |-> (run_cnt >= 8'(BASE_WAIT)));

    p_ready_holds_r10: assert property (@(posedge osc_clk) disable iff (!rst_n)
        (osc_run && $past(clk_ready)) |-> clk_ready);

    p_reserved_zero_r9: assert property (@(posedge osc_clk) disable iff (!rst_n)
        (rd_data[5:4] == 2'b00) && (rd_data[1:0] == 2'b00));

    p_gate_tracks_r8: assert property (@(negedge osc_clk) disable iff (!rst_n)
        sys_clk_en == $past(clk_ready));
endmodule

bind osc_wait_gate osc_wait_gate_chk #(.BASE_WAIT(BASE_WAIT)) u_chk (
    .osc_clk    (osc_clk),
    .rst_n      (rst_n),
    .sleep_req  (sleep_req),
    .rd_data    (rd_data),
    .osc_run    (osc_run),
    .clk_ready  (clk_ready),
    .sys_clk_en (sys_clk_en)
);

// File: tb/tb_osc_wait_gate.sv
// Bench for osc_wait_gate: directed corners plus seeded random stimulus,
// compared each cycle against a bench model built from the requirements.
module tb_osc_wait_gate;
    logic       osc_clk = 1'b0;
    logic       rst_n   = 1'b0;
    logic       wr_en   = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       sleep_req = 1'b0;
    logic [7:0] rd_data;
    logic       osc_run, clk_ready, sys_clk_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Model state
    bit       m_en, m_runq, m_rdy, m_gate;
    bit [1:0] m_wsel;
    int       m_cnt, m_lim;

    osc_wait_gate dut (
        .osc_clk(osc_clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .sleep_req(sleep_req), .rd_data(rd_data), .osc_run(osc_run),
        .clk_ready(clk_ready), .sys_clk_en(sys_clk_en)
    );

    always #4 osc_clk = ~osc_clk;   // 125 MHz

    function automatic int exp_wait(input bit [1:0] code);
        return 8 << (3 - code);
    endfunction

    task automatic check(input int act, input int exp, input string req);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // One cycle: drive at posedge+2, model negedge and posedge, compare at posedge+1.
    task automatic step(input bit wr, input bit [7:0] d, input bit slp);
        bit run, start, exp_run, exp_rdy;
        wr_en = wr; wr_data = d; sleep_req = slp;
        #1;
        check(clk_ready, m_rdy & m_en & ~slp, "R6");
        @(negedge osc_clk);
        m_gate = m_rdy & m_en & ~slp;
        @(posedge osc_clk);
        run   = m_en & ~slp;
        start = run & ~m_runq;
        if (!run) begin
            m_cnt = 0; m_rdy = 0;
        end else if (start) begin
            m_lim = exp_wait(m_wsel); m_cnt = 1; m_rdy = (m_cnt == m_lim);
        end else if (!m_rdy) begin
            m_cnt++; m_rdy = (m_cnt == m_lim);
        end
        m_runq = run;
        if (wr) begin
            m_en = d[2]; m_wsel = d[7:6];
        end
        #1;
        exp_run = m_en & ~slp;
        exp_rdy = m_rdy & exp_run;
        check(osc_run, exp_run, "R2");
        check(clk_ready, exp_rdy, "R3");
        check(rd_data, {m_wsel, 2'b00, exp_rdy, m_en, 2'b00}, "R9");
        check(sys_clk_en, m_gate, "R8");
        #1;
    endtask

    task automatic wait_ready(output int n);
        n = 0;
        while (n < 300) begin
            step(1'b0, 8'h00, 1'b0);
            n++;
            if (clk_ready) break;
        end
    endtask

    initial begin
        int n;
        void'($urandom(32'd20240611));
        m_en = 1; m_wsel = 0; m_runq = 0; m_rdy = 0; m_gate = 0; m_cnt = 0; m_lim = 64;
        repeat (3) @(posedge osc_clk);
        #1;
        // R1: reset state
        check(rd_data, 8'h04, "R1");
        check(osc_run, 1, "R1");
        check(clk_ready, 0, "R1");
        check(sys_clk_en, 0, "R1");
        #1;
        rst_n = 1'b1;
        // R1/R3: default wait from reset release
        wait_ready(n);
        check(n, exp_wait(2'd0), "R1");
        // R10: ready holds while running
        repeat (10) step(1'b0, 8'h00, 1'b0);
        check(clk_ready, 1, "R10");
        // R5/R3/R6: each code via software restart
        for (int c = 0; c < 4; c++) begin
            step(1'b1, {c[1:0], 6'b0}, 1'b0);
            check(clk_ready, 0, "R6");
            step(1'b0, 8'h00, 1'b0);
            step(1'b1, {c[1:0], 6'b000100}, 1'b0);
            wait_ready(n);
            check(n, exp_wait(c[1:0]), "R5");
        end
        // R7: code rewritten mid-count keeps the short wait
        step(1'b1, 8'hC0, 1'b0);
        step(1'b1, 8'hC4, 1'b0);
        repeat (3) step(1'b0, 8'h00, 1'b0);
        step(1'b1, 8'h04, 1'b0);
        wait_ready(n);
        check(n + 4, exp_wait(2'd3), "R7");
        check(rd_data[7:6], 0, "R7");
        // R4: sleep exit restarts full wait
        repeat (5) step(1'b0, 8'h00, 1'b1);
        check(osc_run, 0, "R4");
        wait_ready(n);
        check(n, exp_wait(2'd0), "R4");
        // R9: writes to reserved and ready bits ignored
        step(1'b1, 8'h3B, 1'b0);
        check(rd_data & 8'h33, 0, "R9");
        check(rd_data[2], 0, "R9");
        step(1'b1, 8'hFF, 1'b0);
        check(rd_data & 8'h33, 0, "R9");
        // Random mix
        begin
            bit slp = 0;
            for (int i = 0; i < 4000; i++) begin
                bit wr = ($urandom % 16) == 0;
                if (($urandom % 40) == 0) slp = ~slp;
                step(wr, 8'($urandom), slp);
            end
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule